// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt and Status Flag Unit

This block produces the periodic-rate interrupt of a legacy real-time clock and holds the clock's interrupt status byte. A 32.768 kHz time-base strobe (`tick`, one clock wide, or held high to advance on every clock) feeds a down-counter. The counter's period comes from a 4-bit rate selector in the rate register. The enable register gates three interrupt sources: the periodic divider and two event pulses that arrive from outside, alarm-match and update-ended. Each source that fires sets a summary bit and its own bit in the status register, and asks for the level interrupt `irq`.

An external `legacy_mode` input, driven by a high-precision system timer that has taken over the legacy interrupt routing, blocks every attempt to raise `irq`. It never blocks lowering, so a line that was already high still drops when software reads the status register. The same input also stops the periodic divider. Software reaches the three registers through a byte port. It has a one-cycle write strobe and combinational read data. Reading the status register clears it.

Top module: `rtc_pirq_unit`

## Requirements
- R1: After a synchronous active-high reset, `irq` is 0, and the rate register (address 0xA), the enable register (0xB) and the status register (0xC) all read 0.
- R2: The rate and enable registers read back the full byte last written. Writes to the status register at 0xC are ignored.
- R3: The rate selector is bits 3:0 of the rate register. Selector 0 produces no periodic events. Selectors 1 and 2 act as 8 and 9. An effective selector e gives a period of 2^(e-1) time-base ticks, so selector 3 gives 4 ticks and selector 15 gives 16384 ticks.
- R4: The divider runs only when the selector is nonzero and enable-register bit 6 is 1. Each period expiry sets status bits 7 and 6 (value 0xC0).
- R5: An alarm pulse sets status bits 7 and 5 (0xA0) only when enable bit 5 is 1. An update-ended pulse sets status bits 7 and 4 (0x90) only when enable bit 4 is 1. With its enable bit at 0, a pulse changes neither the status byte nor `irq`.
- R6: When `legacy_mode` is 0, any event that sets status bits sets `irq` at the same clock edge.
- R7: When `legacy_mode` is 1, `irq` never rises, but the status bits of enabled alarm and update events are still recorded.
- R8: Reading address 0xC returns the status byte. At that clock edge it clears every status bit and lowers `irq`, whatever the state of `legacy_mode`.
- R9: When `legacy_mode` is 1, the divider is held at its full period. After `legacy_mode` returns to 0, the first periodic event comes a full period later.
- R10: A write to the rate or enable register restarts the period count. The counter is reloaded on the clock after the write, and counting resumes from the next time-base tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe, one pulse per 32.768 kHz period |
| legacy_mode | input | 1 | High-precision timer owns the legacy interrupts: block raising `irq`, stop the divider |
| evt_alarm | input | 1 | Alarm-match event pulse |
| evt_update | input | 1 | Update-ended event pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status when addressed to 0xC) |
| addr | input | 4 | Register address: 0xA rate, 0xB enable, 0xC status |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume the bench waits one idle clock after each register write before starting to count, so the reload from R10 lands before the first counted tick. The bench drives every input right after a rising edge and holds each strobe for exactly one clock. When it measures a period, it keeps `tick` high and counts rising edges until `irq` appears. Every rate selector is swept this way, and the counts are compared with a period the bench works out from the selector.

// File: rtl/rtc_pirq_pkg.sv
package rtc_pirq_pkg;

  localparam int REG_W  = 8;
  localparam int ADDR_W = 4;
  localparam int SEL_W  = 4;
  localparam int CNT_W  = 16;

  localparam logic [ADDR_W-1:0] ADDR_RATE   = 4'hA;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 4'hB;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'hC;

  // enable bits share positions with the status bits they guard
  localparam int BIT_SUMMARY  = 7;
  localparam int BIT_PERIODIC = 6;
  localparam int BIT_ALARM    = 5;
  localparam int BIT_UPDATE   = 4;

  // selectors 1 and 2 are folded up onto slower rates
  function automatic logic [SEL_W:0] effective_sel(input logic [SEL_W-1:0] sel);
    if (sel == 4'd1 || sel == 4'd2)
      return {1'b0, sel} + 5'd7;
    return {1'b0, sel};
  endfunction

  // ticks per periodic event, 0 when the selector disables the divider
  function automatic logic [31:0] period_ticks(input logic [SEL_W-1:0] sel);
    logic [SEL_W:0] e;
    e = effective_sel(sel);
    if (e == '0)
      return 32'd0;
    return 32'd1 << (e - 5'd1);
  endfunction

  // status byte contributed by one event kind
  function automatic logic [REG_W-1:0] flag_byte(input int which);
    logic [REG_W-1:0] b;
    b = '0;
    b[BIT_SUMMARY] = 1'b1;
    b[which]       = 1'b1;
    return b;
  endfunction

endpackage

// File: rtl/rtc_pirq_regs.sv
module rtc_pirq_regs
  import rtc_pirq_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rate_reg,
  output logic [DW-1:0] enable_reg,
  output logic          cfg_reload
);

  logic hit_rate, hit_enable;
  assign hit_rate   = wr_en && (addr == ADDR_RATE);
  assign hit_enable = wr_en && (addr == ADDR_ENABLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_reg   <= '0;
      enable_reg <= '0;
      cfg_reload <= 1'b0;
    end else begin
      if (hit_rate)   rate_reg   <= wr_data;
      if (hit_enable) enable_reg <= wr_data;
      cfg_reload <= hit_rate || hit_enable;
    end
  end

  // R10: the reload request follows every configuration write by one clock
  a_r10_reload_follows_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_RATE || addr == ADDR_ENABLE)) |=> cfg_reload);

  // R2: the status address never touches the configuration bytes
  a_r2_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_STATUS) |=> ($stable(rate_reg) && $stable(enable_reg)));

endmodule

// File: rtl/rtc_pirq_divider.sv
module rtc_pirq_divider
  import rtc_pirq_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [SW-1:0] sel,
  input  logic          periodic_en,
  input  logic          legacy_mode,
  input  logic          reload,
  output logic          per_fire,
  output logic          div_run
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] period;
  logic          expiring;

  assign period   = CW'(period_ticks(sel));
  assign div_run  = (sel != '0) && periodic_en && !legacy_mode;
  assign expiring = (cnt <= CW'(1));
  assign per_fire = div_run && !reload && tick && expiring;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (!div_run || reload)
      cnt <= period;
    else if (tick)
      cnt <= expiring ? period : cnt - CW'(1);
  end

  // R9: a stopped divider sits at its full period
  a_r9_stopped_holds_period: assert property (@(posedge clk) disable iff (rst)
    !div_run |=> (cnt == $past(period)));

  // R10: a reload request restarts the count from the full period
  a_r10_reload_restarts: assert property (@(posedge clk) disable iff (rst)
    reload |=> (cnt == $past(period)));

  // R4: a running divider stays inside its period
  a_r4_count_in_range: assert property (@(posedge clk) disable iff (rst)
    (div_run && $past(div_run) && !$past(reload) && $stable(sel)) |-> (cnt <= period));

endmodule

// File: rtl/rtc_pirq_flags.sv
module rtc_pirq_flags
  import rtc_pirq_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          per_fire,
  input  logic          evt_alarm,
  input  logic          evt_update,
  input  logic          alarm_en,
  input  logic          update_en,
  input  logic          legacy_mode,
  input  logic          rd_clear,
  output logic [DW-1:0] status,
  output logic          irq
);

  logic [DW-1:0] set_bits;
  logic          raise_req;
  logic          raise_ok;

  always_comb begin
    set_bits = '0;
    if (per_fire)                set_bits = set_bits | flag_byte(BIT_PERIODIC);
    if (evt_alarm && alarm_en)   set_bits = set_bits | flag_byte(BIT_ALARM);
    if (evt_update && update_en) set_bits = set_bits | flag_byte(BIT_UPDATE);
  end

  assign raise_req = |set_bits;
  assign raise_ok  = raise_req && !legacy_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (rd_clear ? '0 : status) | set_bits;
      if (raise_ok)
        irq <= 1'b1;
      else if (rd_clear)
        irq <= 1'b0;
    end
  end

  // R7: legacy mode never lets the line rise
  a_r7_no_raise_in_legacy: assert property (@(posedge clk) disable iff (rst)
    (legacy_mode && !irq) |=> !irq);

  // R8: a status read lowers the line unless a fresh raise arrives with it
  a_r8_read_lowers: assert property (@(posedge clk) disable iff (rst)
    (rd_clear && !raise_ok) |=> !irq);

  // R6: the line is high only with the summary flag recorded
  a_r6_irq_has_summary: assert property (@(posedge clk) disable iff (rst)
    irq |-> status[BIT_SUMMARY]);

  // R4: a periodic expiry leaves both periodic flags set
  a_r4_fire_sets_flags: assert property (@(posedge clk) disable iff (rst)
    per_fire |=> (status[BIT_SUMMARY] && status[BIT_PERIODIC]));

  // R5: a disabled alarm pulse alone never changes the alarm flag
  a_r5_alarm_gated: assert property (@(posedge clk) disable iff (rst)
    (evt_alarm && !alarm_en && !rd_clear) |=> $stable(status[BIT_ALARM]));

endmodule

// File: rtl/rtc_pirq_unit.sv
module rtc_pirq_unit
  import rtc_pirq_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int AW = ADDR_W,
  parameter int SW = SEL_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          legacy_mode,
  input  logic          evt_alarm,
  input  logic          evt_update,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          irq
);

  logic [DW-1:0] rate_reg, enable_reg, status;
  logic          cfg_reload, per_fire, div_run, rd_clear;

  assign rd_clear = rd_en && (addr == ADDR_STATUS);

  rtc_pirq_regs #(.DW(DW), .AW(AW)) regs_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .rate_reg   (rate_reg),
    .enable_reg (enable_reg),
    .cfg_reload (cfg_reload)
  );

  rtc_pirq_divider #(.SW(SW), .CW(CW)) div_i (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .sel         (rate_reg[SW-1:0]),
    .periodic_en (enable_reg[BIT_PERIODIC]),
    .legacy_mode (legacy_mode),
    .reload      (cfg_reload),
    .per_fire    (per_fire),
    .div_run     (div_run)
  );

  rtc_pirq_flags #(.DW(DW)) flags_i (
    .clk         (clk),
    .rst         (rst),
    .per_fire    (per_fire),
    .evt_alarm   (evt_alarm),
    .evt_update  (evt_update),
    .alarm_en    (enable_reg[BIT_ALARM]),
    .update_en   (enable_reg[BIT_UPDATE]),
    .legacy_mode (legacy_mode),
    .rd_clear    (rd_clear),
    .status      (status),
    .irq         (irq)
  );

  always_comb begin
    unique case (addr)
      ADDR_RATE:   rd_data = rate_reg;
      ADDR_ENABLE: rd_data = enable_reg;
      ADDR_STATUS: rd_data = status;
      default:     rd_data = '0;
    endcase
  end

  // R9: legacy mode keeps the divider from firing at all
  a_r9_legacy_no_fire: assert property (@(posedge clk) disable iff (rst)
    legacy_mode |=> !$rose(status[BIT_PERIODIC]) || $past(per_fire));

  // R1: the clock after reset leaves the line low
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !irq);

endmodule

// File: tb/rtc_pirq_unit_tb_top.sv
module rtc_pirq_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       legacy_mode = 1'b0;
  logic       evt_alarm = 1'b0;
  logic       evt_update = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_pirq_unit dut_i (
    .clk(clk), .rst(rst), .tick(tick), .legacy_mode(legacy_mode),
    .evt_alarm(evt_alarm), .evt_update(evt_update), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input int actual, input int expected);
    n_checks++;
    if (actual !== expected) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  function automatic int expected_period(input int sel);
    int e;
    int p;
    e = sel;
    if (sel == 1 || sel == 2) e = sel + 7;
    if (e == 0) return 0;
    p = 1;
    for (int k = 1; k < e; k++) p = p * 2;
    return p;
  endfunction

  // write, then one idle clock so the restart lands before counting
  task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic pulse_alarm();
    evt_alarm = 1'b1; @(posedge clk); #1; evt_alarm = 1'b0;
  endtask

  task automatic pulse_update();
    evt_update = 1'b1; @(posedge clk); #1; evt_update = 1'b0;
  endtask

  task automatic ticks_until_irq(input int limit, output int n);
    n = 0;
    tick = 1'b1;
    while (!irq && n < limit) begin
      @(posedge clk); #1;
      n++;
    end
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    int p;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    check("R1", "irq after reset", int'(irq), 0);
    reg_read(4'hA, d); check("R1", "rate after reset", int'(d), 0);
    reg_read(4'hB, d); check("R1", "enable after reset", int'(d), 0);
    reg_read(4'hC, d); check("R1", "status after reset", int'(d), 0);

    // R2 readback and read-only status
    reg_write(4'hA, 8'h2F); reg_read(4'hA, d); check("R2", "rate readback", int'(d), 'h2F);
    reg_write(4'hB, 8'h0E); reg_read(4'hB, d); check("R2", "enable readback", int'(d), 'h0E);
    reg_write(4'hC, 8'hFF); reg_read(4'hC, d); check("R2", "status write ignored", int'(d), 0);
    check("R2", "irq after status write", int'(irq), 0);

    // R3 / R4 / R6 sweep of every rate selector
    for (int sel = 0; sel < 16; sel++) begin
      reg_write(4'hB, 8'h00);
      reg_read(4'hC, d);
      reg_write(4'hA, 8'(sel));
      reg_write(4'hB, 8'h40);
      p = expected_period(sel);
      if (p == 0) begin
        ticks_until_irq(40, n);
        check("R3", "selector 0 stays silent", int'(irq), 0);
        reg_read(4'hC, d);
        check("R3", "selector 0 status", int'(d), 0);
      end else begin
        ticks_until_irq(p + 4, n);
        check("R3", $sformatf("ticks for selector %0d", sel), n, p);
        reg_read(4'hC, d);
        check("R4", $sformatf("status for selector %0d", sel), int'(d), 'hC0);
        check("R8", "irq lowered by read", int'(irq), 0);
      end
    end

    // R4 divider gated by enable bit 6
    reg_write(4'hB, 8'h00);
    reg_read(4'hC, d);
    reg_write(4'hA, 8'h03);
    ticks_until_irq(30, n);
    check("R4", "no events with bit 6 clear", int'(irq), 0);
    reg_read(4'hC, d);
    check("R4", "status with bit 6 clear", int'(d), 0);

    // R5 / R6 event gating
    reg_write(4'hB, 8'h20);
    pulse_update();
    check("R5", "disabled update irq", int'(irq), 0);
    reg_read(4'hC, d); check("R5", "disabled update status", int'(d), 0);
    pulse_alarm();
    check("R6", "alarm raises irq", int'(irq), 1);
    reg_read(4'hC, d); check("R5", "alarm status", int'(d), 'hA0);
    reg_write(4'hB, 8'h10);
    pulse_alarm();
    check("R5", "disabled alarm irq", int'(irq), 0);
    pulse_update();
    check("R6", "update raises irq", int'(irq), 1);
    reg_read(4'hC, d); check("R5", "update status", int'(d), 'h90);
    check("R8", "irq low after update read", int'(irq), 0);

    // R7 legacy blocks raising, still records
    reg_write(4'hB, 8'h20);
    legacy_mode = 1'b1;
    pulse_alarm();
    check("R7", "irq blocked in legacy", int'(irq), 0);
    reg_read(4'hC, d); check("R7", "alarm recorded in legacy", int'(d), 'hA0);

    // R8 lowering honoured in legacy
    legacy_mode = 1'b0;
    pulse_alarm();
    check("R6", "alarm raises irq again", int'(irq), 1);
    legacy_mode = 1'b1;
    @(posedge clk); #1;
    check("R7", "high line held in legacy", int'(irq), 1);
    reg_read(4'hC, d); check("R8", "status read in legacy", int'(d), 'hA0);
    check("R8", "irq lowered in legacy", int'(irq), 0);

    // R9 legacy stops the divider, full period afterwards
    reg_write(4'hA, 8'h03);
    reg_write(4'hB, 8'h40);
    ticks_until_irq(20, n);
    check("R9", "no periodic irq in legacy", int'(irq), 0);
    reg_read(4'hC, d); check("R9", "no periodic flag in legacy", int'(d), 0);
    legacy_mode = 1'b0;
    ticks_until_irq(12, n);
    check("R9", "full period after legacy", n, 4);
    reg_read(4'hC, d);

    // R10 rewrite restarts the count
    reg_write(4'hA, 8'h04);
    tick = 1'b1;
    repeat (5) begin @(posedge clk); #1; end
    tick = 1'b0;
    check("R10", "no event mid-period", int'(irq), 0);
    reg_write(4'hA, 8'h04);
    ticks_until_irq(20, n);
    check("R10", "full period after rewrite", n, 8);
    reg_read(4'hC, d);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule